// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Masks

This block holds four alarm fields: seconds, minutes, hours and day of month, all in packed BCD. It compares them with the current time, which a separate counter supplies on four byte-wide inputs, one strobe per elapsed second. Bit 7 of each alarm field is a "don't care" flag. The pattern of these flags picks one of five repeat periods: once a month, daily, hourly, every minute or every second. When the time matches under the selected period, the block emits a single-cycle interrupt pulse. The pulse is gated by an enable bit in a small control register.

Software programs the fields through a byte-wide register port. A write whose value decodes to an impossible time is discarded, and the old contents stay in place. A read returns the stored byte exactly as it was written.

Top module: `rtc_alarm`

## Requirements
- R1: After reset, irq_o is low. The registers read seconds 0x00, minutes 0x00, hours 0x00, date 0x01 and control 0x00.
- R2: The register addresses are 0 for seconds, 1 for minutes, 2 for hours, 3 for date and 4 for control. A read returns the stored byte unchanged, bit 7 included. Any other address reads 0x00.
- R3: A write to seconds or minutes is kept only if its low 7 bits, decoded as tens nibble × 10 + ones nibble, give at most 59. Otherwise the register keeps its old value.
- R4: A write to hours is kept only if its low 6 bits decode to at most 23. Otherwise it is ignored.
- R5: A write to date is kept only if its low 5 bits are non-zero. Otherwise it is ignored.
- R6: When no flag is set, the block matches only when seconds, minutes, hours and date all equal the current time. Each field is compared on its low 7, 7, 6 and 5 bits.
- R7: When only the date flag is set, the block matches on seconds, minutes and hours, so the alarm repeats daily.
- R8: When the date and hours flags are set and the others are clear, the block matches on seconds and minutes, so the alarm repeats hourly.
- R9: When the date, hours and minutes flags are set and the seconds flag is clear, the block matches on seconds only, so the alarm repeats every minute.
- R10: Any other flag pattern matches on every seconds strobe.
- R11: A rising edge of tick_i that meets a match raises irq_o for exactly one cycle. The pulse appears in the cycle after the clock edge that sampled the rising edge. A tick_i held high for several cycles gives only one pulse.
- R12: Control bit 7 enables the interrupt. While it is clear, no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| tick_i | input | 1 | Seconds strobe from the time counter |
| now_sec_i | input | 8 | Current seconds, BCD |
| now_min_i | input | 8 | Current minutes, BCD |
| now_hour_i | input | 8 | Current hours, BCD |
| now_date_i | input | 8 | Current day of month, BCD |
| irq_o | output | 1 | Alarm interrupt pulse |

## Verification
The bench drives each repeat mode with one time that should match and one that differs only in a field that mode still compares. A design with a mis-decoded flag pattern either fires on the near-miss or stays silent on the match. It writes values just past each range limit, including hex ones nibbles such as 0x5A, which decodes to 60. A checker that tests the raw byte rather than the decoded value would let these writes through, and the readback shows it. A held seconds strobe and a cleared enable bit cover the two ways a design could send pulses that nobody asked for: a level-sensitive trigger repeats the pulse, and a missing gate fires while disabled.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NFIELD    = 4;
  localparam int F_SEC     = 0;
  localparam int F_MIN     = 1;
  localparam int F_HOUR    = 2;
  localparam int F_DATE    = 3;
  localparam int ADDR_CTRL = 4;
  localparam int FLAG_BIT  = 7;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MIN,
    RPT_SEC
  } rpt_mode_e;

  // significant value bits of each field
  function automatic logic [7:0] field_bits(input int idx);
    case (idx)
      F_SEC, F_MIN: return 8'h7F;
      F_HOUR:       return 8'h3F;
      default:      return 8'h1F;
    endcase
  endfunction

  function automatic logic [7:0] bcd_value(input logic [7:0] v);
    logic [7:0] t;
    t = {4'h0, v[7:4]};
    return (t << 3) + (t << 1) + {4'h0, v[3:0]};
  endfunction

  function automatic logic field_ok(input int idx, input logic [7:0] v);
    logic [7:0] d;
    d = bcd_value(v & field_bits(idx));
    case (idx)
      F_SEC, F_MIN: return d <= 8'd59;
      F_HOUR:       return d <= 8'd23;
      default:      return d != 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] field_reset(input int idx);
    return (idx == F_DATE) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int CTRL_EN_BIT = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [7:0]              wdata_i,
  output logic [7:0]              rdata_o,
  output logic [NFIELD-1:0][7:0]  alarm_o,
  output logic                    en_o
);
  logic [NFIELD-1:0][7:0] alarm_q, alarm_d;
  logic [NFIELD-1:0]      alarm_we;
  logic [7:0]             ctrl_q, ctrl_d;
  logic                   ctrl_we;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    always_comb begin
      alarm_we[g] = wr_i && (addr_i == ADDR_W'(g)) && field_ok(g, wdata_i);
      alarm_d[g]  = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          alarm_q[g] <= field_reset(g);
      else if (alarm_we[g]) alarm_q[g] <= alarm_d[g];
    end
  end

  always_comb begin
    ctrl_we = wr_i && (addr_i == ADDR_W'(ADDR_CTRL));
    ctrl_d  = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= 8'h00;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < NFIELD; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = alarm_q[i];
    if (addr_i == ADDR_W'(ADDR_CTRL)) rdata_o = ctrl_q;
  end

  assign alarm_o = alarm_q;
  assign en_o    = ctrl_q[CTRL_EN_BIT];
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic [NFIELD-1:0][7:0] alarm_i,
  input  logic [NFIELD-1:0][7:0] now_i,
  output rpt_mode_e              mode_o,
  output logic                   hit_o
);
  logic [NFIELD-1:0] flag;
  logic [NFIELD-1:0] eq;

  for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
    assign flag[g] = alarm_i[g][FLAG_BIT];
    assign eq[g]   = ((alarm_i[g] ^ now_i[g]) & field_bits(g)) == 8'h00;
  end

  always_comb begin
    case (flag)
      4'b0000: mode_o = RPT_MONTH;
      4'b1000: mode_o = RPT_DAY;
      4'b1100: mode_o = RPT_HOUR;
      4'b1110: mode_o = RPT_MIN;
      default: mode_o = RPT_SEC;
    endcase
  end

  always_comb begin
    case (mode_o)
      RPT_MONTH: hit_o = &eq;
      RPT_DAY:   hit_o = eq[F_SEC] & eq[F_MIN] & eq[F_HOUR];
      RPT_HOUR:  hit_o = eq[F_SEC] & eq[F_MIN];
      RPT_MIN:   hit_o = eq[F_SEC];
      default:   hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic en_i,
  output logic irq_o
);
  logic tick_q;
  logic irq_q, irq_d;

  always_comb irq_d = tick_i & ~tick_q & hit_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      tick_q <= tick_i;
      irq_q  <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int CTRL_EN_BIT = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              tick_i,
  input  logic [7:0]        now_sec_i,
  input  logic [7:0]        now_min_i,
  input  logic [7:0]        now_hour_i,
  input  logic [7:0]        now_date_i,
  output logic              irq_o
);
  logic [NFIELD-1:0][7:0] alarm_q;
  logic [NFIELD-1:0][7:0] now_bus;
  logic                   alarm_en;
  logic                   hit;
  rpt_mode_e              mode;

  assign now_bus = {now_date_i, now_hour_i, now_min_i, now_sec_i};

  rtc_alarm_regs #(.ADDR_W(ADDR_W), .CTRL_EN_BIT(CTRL_EN_BIT)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .alarm_o (alarm_q),
    .en_o    (alarm_en)
  );

  rtc_alarm_match u_match (
    .alarm_i (alarm_q),
    .now_i   (now_bus),
    .mode_o  (mode),
    .hit_o   (hit)
  );

  rtc_alarm_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .hit_i  (hit),
    .en_i   (alarm_en),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   reg_wr_i,
  input logic [ADDR_W-1:0]      reg_addr_i,
  input logic [7:0]             reg_wdata_i,
  input logic                   tick_i,
  input logic                   irq_o,
  input logic [NFIELD-1:0][7:0] alarm_q,
  input logic                   alarm_en
);
  logic tick_seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_seen <= 1'b0;
    else         tick_seen <= tick_i;
  end

  logic [NFIELD-1:0] all_flags;
  for (genvar g = 0; g < NFIELD; g++) begin : g_f
    assign all_flags[g] = alarm_q[g][FLAG_BIT];
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R11
  AST_IRQ_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(tick_i)); // R11
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(alarm_en)); // R12
  AST_EVERY_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !tick_seen && alarm_en && (&all_flags)) |=> irq_o); // R10
  AST_SEC_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_W'(F_SEC) && bcd_value(reg_wdata_i & 8'h7F) > 8'd59)
    |=> $stable(alarm_q[F_SEC])); // R3
  AST_HOUR_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_W'(F_HOUR) && bcd_value(reg_wdata_i & 8'h3F) > 8'd23)
    |=> $stable(alarm_q[F_HOUR])); // R4
  AST_DATE_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_W'(F_DATE) && (reg_wdata_i & 8'h1F) == 8'h00)
    |=> $stable(alarm_q[F_DATE])); // R5
  AST_DATE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_q[F_DATE] & 8'h1F) != 8'h00); // R5
endmodule

bind rtc_alarm rtc_alarm_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/rtc_alarm_bench.sv
`timescale 1ns/1ps
module rtc_alarm_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       reg_wr_i;
  logic [2:0] reg_addr_i;
  logic [7:0] reg_wdata_i;
  logic [7:0] reg_rdata_o;
  logic       tick_i;
  logic [7:0] now_sec_i, now_min_i, now_hour_i, now_date_i;
  logic       irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  typedef struct {
    int    due;
    logic  exp;
    string tag;
  } exp_t;
  exp_t sb[$];

  rtc_alarm u_rtc_alarm (.*);

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // monitor: compares irq_o against the scoreboard at every falling edge
  always @(negedge clk_i) begin
    if (rst_ni === 1'b1) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, {7'b0, irq_o}, {7'b0, e.exp});
      end else if (irq_o !== 1'b0) begin
        check("R11 unexpected pulse", {7'b0, irq_o}, 8'h00);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    reg_addr_i = a;
    #1;
    check(tag, reg_rdata_o, exp);
  endtask

  task automatic tick(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                      input logic [7:0] d, input logic exp, input string tag, input int hold = 1);
    exp_t e;
    @(negedge clk_i);
    now_sec_i = s; now_min_i = m; now_hour_i = h; now_date_i = d;
    tick_i = 1'b1;
    e.due = cyc + 1; e.exp = exp; e.tag = tag;
    sb.push_back(e);
    repeat (hold) @(negedge clk_i);
    tick_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; reg_wr_i = 1'b0; reg_addr_i = 3'd0; reg_wdata_i = 8'h00;
    tick_i = 1'b0; now_sec_i = 8'h00; now_min_i = 8'h00; now_hour_i = 8'h00; now_date_i = 8'h01;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1 irq after reset", {7'b0, irq_o}, 8'h00);
    rd(3'd0, 8'h00, "R1 sec reset");
    rd(3'd1, 8'h00, "R1 min reset");
    rd(3'd2, 8'h00, "R1 hour reset");
    rd(3'd3, 8'h01, "R1 date reset");
    rd(3'd4, 8'h00, "R1 ctrl reset");

    wr(3'd4, 8'h80);  rd(3'd4, 8'h80, "R2 ctrl readback");
    wr(3'd0, 8'h30);  rd(3'd0, 8'h30, "R2 sec readback");
    wr(3'd1, 8'h15);  rd(3'd1, 8'h15, "R2 min readback");
    wr(3'd2, 8'h12);  rd(3'd2, 8'h12, "R2 hour readback");
    wr(3'd3, 8'h25);  rd(3'd3, 8'h25, "R2 date readback");
    rd(3'd5, 8'h00, "R2 unmapped address");

    wr(3'd0, 8'h60);  rd(3'd0, 8'h30, "R3 sec 0x60 rejected");
    wr(3'd0, 8'h5A);  rd(3'd0, 8'h30, "R3 sec 0x5A rejected");
    wr(3'd1, 8'hFF);  rd(3'd1, 8'h15, "R3 min 0xFF rejected");
    wr(3'd1, 8'h59);  rd(3'd1, 8'h59, "R3 min 0x59 accepted");
    wr(3'd1, 8'h15);
    wr(3'd2, 8'h24);  rd(3'd2, 8'h12, "R4 hour 0x24 rejected");
    wr(3'd2, 8'h23);  rd(3'd2, 8'h23, "R4 hour 0x23 accepted");
    wr(3'd2, 8'h12);
    wr(3'd3, 8'h00);  rd(3'd3, 8'h25, "R5 date 0x00 rejected");
    wr(3'd3, 8'hE0);  rd(3'd3, 8'h25, "R5 date 0xE0 rejected");

    // R6 monthly
    tick(8'h30, 8'h15, 8'h12, 8'h25, 1'b1, "R6 monthly match");
    tick(8'h30, 8'h15, 8'h12, 8'h26, 1'b0, "R6 monthly date differs");
    tick(8'h31, 8'h15, 8'h12, 8'h25, 1'b0, "R6 monthly sec differs");
    // R7 daily
    wr(3'd3, 8'hA5);  rd(3'd3, 8'hA5, "R2 date flag readback");
    tick(8'h30, 8'h15, 8'h12, 8'h09, 1'b1, "R7 daily match");
    tick(8'h30, 8'h15, 8'h13, 8'h09, 1'b0, "R7 daily hour differs");
    // R8 hourly
    wr(3'd2, 8'h92);
    tick(8'h30, 8'h15, 8'h07, 8'h09, 1'b1, "R8 hourly match");
    tick(8'h30, 8'h16, 8'h07, 8'h09, 1'b0, "R8 hourly min differs");
    // R9 minute
    wr(3'd1, 8'h95);
    tick(8'h30, 8'h44, 8'h07, 8'h09, 1'b1, "R9 minute match");
    tick(8'h31, 8'h44, 8'h07, 8'h09, 1'b0, "R9 minute sec differs");
    // R10 all flags
    wr(3'd0, 8'hB0);
    tick(8'h02, 8'h03, 8'h04, 8'h05, 1'b1, "R10 all flags fire");
    // R10 only seconds flag
    wr(3'd1, 8'h15); wr(3'd2, 8'h12); wr(3'd3, 8'h25);
    tick(8'h11, 8'h22, 8'h01, 8'h02, 1'b1, "R10 seconds flag only fires");
    // R11 held strobe gives one pulse
    tick(8'h11, 8'h22, 8'h01, 8'h02, 1'b1, "R11 held tick single pulse", 4);
    // R12 enable gating
    wr(3'd4, 8'h00);
    tick(8'h11, 8'h22, 8'h01, 8'h02, 1'b0, "R12 disabled no pulse");
    wr(3'd4, 8'h7F);
    tick(8'h11, 8'h22, 8'h01, 8'h02, 1'b0, "R12 bit7 clear no pulse");
    wr(3'd4, 8'h80);
    tick(8'h11, 8'h22, 8'h01, 8'h02, 1'b1, "R12 re-enabled pulse");

    repeat (4) @(negedge clk_i);
    if (sb.size() != 0) check("R11 pending expectations", 8'(sb.size()), 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule